// File: doc/BRIEF.md
# Video Line Timing and Blanking Generator

This block runs free horizontal and vertical counters from the 27 MHz sample clock. It covers both 525-line/60 Hz and 625-line/50 Hz television timing, in interlaced or non-interlaced scan. From the counter state it produces the following outputs:

- a line sync pulse;
- a field flag;
- a per-sample vertical-blanking qualifier, which follows either a full or a partial blanking policy and honours the mid-line (half-line) boundaries of interlaced frames;
- an active-video window, which spans either the whole digital line or a slightly narrower analog-width line.

A video encoder uses these qualifiers to decide, sample by sample, whether incoming pixel data may reach the output waveform. The standard select and the scan select are sampled only at the frame boundary, so a write to them never tears a frame. The line sync and the field flag can be delayed by 0 to 3 clocks against the data qualifiers, and each can be inverted on its own. The blanking policy, the window width, the delay and the inversions act at once.

Top module: `video_line_timer`

## Requirements
- R1: While `rstN` is low the outputs read `lineNum`=1, `sampleNum`=0, `vbiLine`=0, `activeVideo`=0, `hSyncOut`=`hsInvert` and `fieldOut`=`fieldInvert`. The first frame after reset is 525-line interlaced, whatever the select inputs are. One clock after release the outputs reflect line 1, sample 0.
- R2: `sampleNum` counts 0 to H_TOTAL-1 and then wraps. H_TOTAL is 1716 clocks in 525 mode and 1728 clocks in 625 mode (both are parameters).
- R3: `lineNum` counts from 1 and advances at each line wrap. A frame has 525 or 625 lines when interlaced, and 262 or 312 lines when non-interlaced.
- R4: `std625` (1 = 625-line timing) and `progressive` (1 = non-interlaced) are sampled only on the last sample of the last line of a frame. They govern the next frame.
- R5: The raw line sync is high for samples 0 to HSYNC_WIDTH-1 of every line. HSYNC_WIDTH defaults to 128.
- R6: The raw field flag is 0 in the first field and 1 from line 264 (525) or line 313 (625) to the end of an interlaced frame. It is always 0 in non-interlaced mode.
- R7: 525 interlaced with `fullVbi`=1 blanks lines 1–19, the second half of line 263 (sample ≥ H_TOTAL/2) and lines 264–282. With `fullVbi`=0 it blanks lines 1–9, the second half of 263 and lines 264–272.
- R8: 625 interlaced with `fullVbi`=1 blanks the second half of line 623, lines 624–625, lines 1–22 and lines 311–335. With `fullVbi`=0 the ranges become 1–5 and 311–318, and the half of line 623 and lines 624–625 stay blanked. Line 23 is never blanked.
- R9: Non-interlaced mode blanks whole lines only. These are lines 1–19 (full) or 1–9 (partial) for 525, and lines 1–22 (full) or 1–5 (partial) for 625.
- R10: `activeVideo` is high on non-blanked samples inside the window. The window is [S, S+1440) with `trimLine`=0 and [S+10, S+1430) with `trimLine`=1. S is 244 (525) or 264 (625).
- R11: `hSyncOut` and `fieldOut` show the raw sync values delayed by `syncDelay` clocks (0–3). The other outputs are not delayed.
- R12: `hsInvert`=1 inverts `hSyncOut` and `fieldInvert`=1 inverts `fieldOut`. Each acts independently and at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| std625 | input | 1 | 1 selects 625-line timing, 0 selects 525 (taken at frame end) |
| progressive | input | 1 | 1 selects non-interlaced scan (taken at frame end) |
| fullVbi | input | 1 | 1 selects the full blanking policy, 0 the partial one |
| trimLine | input | 1 | 1 selects the 1420-clock active window |
| syncDelay | input | 2 | Delay of the sync outputs in clocks |
| hsInvert | input | 1 | Inverts the line sync output |
| fieldInvert | input | 1 | Inverts the field flag output |
| hSyncOut | output | 1 | Line sync pulse |
| fieldOut | output | 1 | Field flag |
| vbiLine | output | 1 | Sample lies in vertical blanking |
| activeVideo | output | 1 | Sample lies in the active picture |
| lineNum | output | 10 | Line number of the current sample |
| sampleNum | output | 11 | Sample index within the line |

## Verification
On every cycle, the in-line assertions check several properties of the counters and outputs:

- the sample counter stays below the current line total;
- the line counter moves only at a line wrap;
- the latched standard and scan mode change only at the frame boundary;
- the active flag stays inside the window bounds;
- line 23 of a 625 interlaced frame is never blanked;
- no line past 22 of a non-interlaced field is blanked.

Some behaviour can only be shown by the bench scenarios, which compare a behavioural model every cycle:

- the exact line sets of each blanking policy, including the mid-line switch on lines 263 and 623;
- a mode change requested mid-frame being deferred to the next frame;
- the sync delay and the inversions being applied while the data qualifiers stay put.

// File: rtl/vlt_pkg.sv
package vlt_pkg;
  localparam int LINE_W    = 10;
  localparam int SAMP_W    = 11;
  localparam int SYNC_TAPS = 4;
  localparam int DELAY_W   = $clog2(SYNC_TAPS);

  typedef logic [LINE_W-1:0] line_t;
  typedef logic [SAMP_W-1:0] samp_t;

  // frame lengths
  localparam line_t FRAME_525  = line_t'(525);
  localparam line_t FRAME_625  = line_t'(625);
  localparam line_t PROG_525   = line_t'(262);
  localparam line_t PROG_625   = line_t'(312);
  // first line of the second field
  localparam line_t FLD2_525   = line_t'(264);
  localparam line_t FLD2_625   = line_t'(313);
  // lines split at mid-line
  localparam line_t SPLIT_525  = line_t'(263);
  localparam line_t SPLIT_625  = line_t'(623);
  localparam line_t TAIL_625   = line_t'(624);
  // blanking limits
  localparam line_t TOP_FULL_525  = line_t'(19);
  localparam line_t TOP_PART_525  = line_t'(9);
  localparam line_t BOT_FULL_525  = line_t'(282);
  localparam line_t BOT_PART_525  = line_t'(272);
  localparam line_t TOP_FULL_625  = line_t'(22);
  localparam line_t TOP_PART_625  = line_t'(5);
  localparam line_t BOT_START_625 = line_t'(311);
  localparam line_t BOT_FULL_625  = line_t'(335);
  localparam line_t BOT_PART_625  = line_t'(318);

  typedef struct packed {
    samp_t hCnt;
    line_t lineCnt;
    logic  is625;
    logic  isProg;
    logic  pastMid;
    logic  inSync;
    logic  evenField;
  } vlt_strobes_t;
endpackage

// File: rtl/vlt_counters.sv
module vlt_counters
  import vlt_pkg::*;
#(
  parameter int H_TOTAL_525 = 1716,
  parameter int H_TOTAL_625 = 1728,
  parameter int HSYNC_WIDTH = 128
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         std625,
  input  logic         progressive,
  output vlt_strobes_t strb
);
  localparam samp_t HLAST_525 = samp_t'(H_TOTAL_525 - 1);
  localparam samp_t HLAST_625 = samp_t'(H_TOTAL_625 - 1);
  localparam samp_t HMID_525  = samp_t'(H_TOTAL_525 / 2);
  localparam samp_t HMID_625  = samp_t'(H_TOTAL_625 / 2);
  localparam samp_t HS_W      = samp_t'(HSYNC_WIDTH);

  samp_t hCnt;
  line_t lineCnt;
  logic  cfg625, cfgProg;
  samp_t hLast, hMid;
  line_t frameLines, fld2Start;
  logic  lineEnd, frameEnd;

  always_comb begin
    hLast     = cfg625 ? HLAST_625 : HLAST_525;
    hMid      = cfg625 ? HMID_625 : HMID_525;
    fld2Start = cfg625 ? FLD2_625 : FLD2_525;
    if (cfgProg) frameLines = cfg625 ? PROG_625 : PROG_525;
    else         frameLines = cfg625 ? FRAME_625 : FRAME_525;
    lineEnd  = (hCnt == hLast);
    frameEnd = lineEnd && (lineCnt == frameLines);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCnt    <= '0;
      lineCnt <= line_t'(1);
      cfg625  <= 1'b0;
      cfgProg <= 1'b0;
    end else if (lineEnd) begin
      hCnt <= '0;
      if (frameEnd) begin
        lineCnt <= line_t'(1);
        cfg625  <= std625;
        cfgProg <= progressive;
      end else begin
        lineCnt <= lineCnt + line_t'(1);
      end
    end else begin
      hCnt <= hCnt + samp_t'(1);
    end
  end

  always_comb begin
    strb.hCnt      = hCnt;
    strb.lineCnt   = lineCnt;
    strb.is625     = cfg625;
    strb.isProg    = cfgProg;
    strb.pastMid   = (hCnt >= hMid);
    strb.inSync    = (hCnt < HS_W);
    strb.evenField = !cfgProg && (lineCnt >= fld2Start);
  end

  // R2
  h_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    hCnt <= hLast);
  // R3
  line_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !lineEnd |=> $stable(lineCnt));
  // R4
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !frameEnd |=> ($stable(cfg625) && $stable(cfgProg)));
endmodule

// File: rtl/vlt_decode.sv
module vlt_decode
  import vlt_pkg::*;
#(
  parameter int ACT_START_525 = 244,
  parameter int ACT_START_625 = 264,
  parameter int ACT_LEN       = 1440,
  parameter int TRIM_EDGE     = 10
) (
  input  logic               clk,
  input  logic               rstN,
  input  vlt_strobes_t       strb,
  input  logic               fullVbi,
  input  logic               trimLine,
  input  logic [DELAY_W-1:0] syncDelay,
  input  logic               hsInvert,
  input  logic               fieldInvert,
  output logic               hSyncOut,
  output logic               fieldOut,
  output logic               vbiLine,
  output logic               activeVideo,
  output line_t              lineNum,
  output samp_t              sampleNum
);
  localparam samp_t S525 = samp_t'(ACT_START_525);
  localparam samp_t S625 = samp_t'(ACT_START_625);
  localparam samp_t ALEN = samp_t'(ACT_LEN);
  localparam samp_t TRIM = samp_t'(TRIM_EDGE);

  logic  vbiNext, actNext, inWindow;
  line_t topEnd, botEnd;
  samp_t winStart, winLo, winHi;
  logic  regIs625, regProg;
  logic [SYNC_TAPS-1:0] hsTap, fdTap;

  always_comb begin
    if (strb.isProg) begin
      topEnd = strb.is625 ? (fullVbi ? TOP_FULL_625 : TOP_PART_625)
                          : (fullVbi ? TOP_FULL_525 : TOP_PART_525);
      botEnd = '0;
      vbiNext = (strb.lineCnt <= topEnd);
    end else if (!strb.is625) begin
      topEnd = fullVbi ? TOP_FULL_525 : TOP_PART_525;
      botEnd = fullVbi ? BOT_FULL_525 : BOT_PART_525;
      vbiNext = (strb.lineCnt <= topEnd)
             || (strb.lineCnt == SPLIT_525 && strb.pastMid)
             || (strb.lineCnt >= FLD2_525 && strb.lineCnt <= botEnd);
    end else begin
      topEnd = fullVbi ? TOP_FULL_625 : TOP_PART_625;
      botEnd = fullVbi ? BOT_FULL_625 : BOT_PART_625;
      vbiNext = (strb.lineCnt <= topEnd)
             || (strb.lineCnt == SPLIT_625 && strb.pastMid)
             || (strb.lineCnt >= TAIL_625)
             || (strb.lineCnt >= BOT_START_625 && strb.lineCnt <= botEnd);
    end
  end

  always_comb begin
    winStart = strb.is625 ? S625 : S525;
    winLo    = winStart + (trimLine ? TRIM : samp_t'(0));
    winHi    = winStart + ALEN - (trimLine ? TRIM : samp_t'(0));
    inWindow = (strb.hCnt >= winLo) && (strb.hCnt < winHi);
    actNext  = inWindow && !vbiNext;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vbiLine     <= 1'b0;
      activeVideo <= 1'b0;
      lineNum     <= line_t'(1);
      sampleNum   <= '0;
      regIs625    <= 1'b0;
      regProg     <= 1'b0;
    end else begin
      vbiLine     <= vbiNext;
      activeVideo <= actNext;
      lineNum     <= strb.lineCnt;
      sampleNum   <= strb.hCnt;
      regIs625    <= strb.is625;
      regProg     <= strb.isProg;
    end
  end

  // sync delay line: tap k holds the raw value k clocks behind tap 0
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsTap[0] <= 1'b0;
      fdTap[0] <= 1'b0;
    end else begin
      hsTap[0] <= strb.inSync;
      fdTap[0] <= strb.evenField;
    end
  end

  for (genvar k = 1; k < SYNC_TAPS; k++) begin : g_tap
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hsTap[k] <= 1'b0;
        fdTap[k] <= 1'b0;
      end else begin
        hsTap[k] <= hsTap[k-1];
        fdTap[k] <= fdTap[k-1];
      end
    end
  end

  assign hSyncOut = hsTap[syncDelay] ^ hsInvert;
  assign fieldOut = fdTap[syncDelay] ^ fieldInvert;

  // R10
  act_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    activeVideo |-> (sampleNum >= (regIs625 ? S625 : S525)) &&
                    (sampleNum < (regIs625 ? S625 : S525) + ALEN));
  // R8
  line23_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regIs625 && !regProg && lineNum == line_t'(23)) |-> !vbiLine);
  // R9
  prog_vbi_chk: assert property (@(posedge clk) disable iff (!rstN)
    (regProg && lineNum > TOP_FULL_625) |-> !vbiLine);
endmodule

// File: rtl/video_line_timer.sv
module video_line_timer
  import vlt_pkg::*;
#(
  parameter int H_TOTAL_525   = 1716,
  parameter int H_TOTAL_625   = 1728,
  parameter int HSYNC_WIDTH   = 128,
  parameter int ACT_START_525 = 244,
  parameter int ACT_START_625 = 264,
  parameter int ACT_LEN       = 1440,
  parameter int TRIM_EDGE     = 10
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        std625,
  input  logic        progressive,
  input  logic        fullVbi,
  input  logic        trimLine,
  input  logic [1:0]  syncDelay,
  input  logic        hsInvert,
  input  logic        fieldInvert,
  output logic        hSyncOut,
  output logic        fieldOut,
  output logic        vbiLine,
  output logic        activeVideo,
  output logic [9:0]  lineNum,
  output logic [10:0] sampleNum
);
  vlt_strobes_t strb;

  vlt_counters #(
    .H_TOTAL_525(H_TOTAL_525),
    .H_TOTAL_625(H_TOTAL_625),
    .HSYNC_WIDTH(HSYNC_WIDTH)
  ) u_cnt (
    .clk(clk),
    .rstN(rstN),
    .std625(std625),
    .progressive(progressive),
    .strb(strb)
  );

  vlt_decode #(
    .ACT_START_525(ACT_START_525),
    .ACT_START_625(ACT_START_625),
    .ACT_LEN(ACT_LEN),
    .TRIM_EDGE(TRIM_EDGE)
  ) u_dec (
    .clk(clk),
    .rstN(rstN),
    .strb(strb),
    .fullVbi(fullVbi),
    .trimLine(trimLine),
    .syncDelay(syncDelay),
    .hsInvert(hsInvert),
    .fieldInvert(fieldInvert),
    .hSyncOut(hSyncOut),
    .fieldOut(fieldOut),
    .vbiLine(vbiLine),
    .activeVideo(activeVideo),
    .lineNum(lineNum),
    .sampleNum(sampleNum)
  );
endmodule

// File: tb/video_line_timer_test.sv
`timescale 1ns/1ps
module video_line_timer_test;
  localparam int T525 = 60;
  localparam int T625 = 64;
  localparam int HSW  = 8;
  localparam int S525 = 14;
  localparam int S625 = 18;
  localparam int ALEN = 40;
  localparam int TRIM = 2;

  logic clk = 0;
  logic rstN = 0;
  logic std625 = 1, progressive = 0, fullVbi = 1, trimLine = 0;
  logic [1:0] syncDelay = 0;
  logic hsInvert = 0, fieldInvert = 1;
  logic hSyncOut, fieldOut, vbiLine, activeVideo;
  logic [9:0] lineNum;
  logic [10:0] sampleNum;

  video_line_timer #(
    .H_TOTAL_525(T525), .H_TOTAL_625(T625), .HSYNC_WIDTH(HSW),
    .ACT_START_525(S525), .ACT_START_625(S625), .ACT_LEN(ALEN), .TRIM_EDGE(TRIM)
  ) uut (
    .clk(clk), .rstN(rstN), .std625(std625), .progressive(progressive),
    .fullVbi(fullVbi), .trimLine(trimLine), .syncDelay(syncDelay),
    .hsInvert(hsInvert), .fieldInvert(fieldInvert), .hSyncOut(hSyncOut),
    .fieldOut(fieldOut), .vbiLine(vbiLine), .activeVideo(activeVideo),
    .lineNum(lineNum), .sampleNum(sampleNum)
  );

  always #5 clk = ~clk;

  int nChecks = 0, nErrors = 0;
  bit running = 0, finished = 0;

  task automatic chk(string tag, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s line=%0d sample=%0d actual=%0d expected=%0d",
               tag, lineNum, sampleNum, act, exp);
    end
  endtask

  // inputs seen by the design at the latest rising edge
  bit snap625, snapProg, snapFull, snapTrim;
  always @(posedge clk) begin
    snap625 = std625; snapProg = progressive; snapFull = fullVbi; snapTrim = trimLine;
  end

  function automatic bit vbiRef(int ln, int h, bit is625, bit prog, bit full);
    int half = (is625 ? T625 : T525) / 2;
    if (prog) return ln <= (is625 ? (full ? 22 : 5) : (full ? 19 : 9));
    if (!is625)
      return (ln <= (full ? 19 : 9)) || (ln == 263 && h >= half) ||
             (ln >= 264 && ln <= (full ? 282 : 272));
    return (ln == 623 && h >= half) || (ln >= 624) || (ln <= (full ? 22 : 5)) ||
           (ln >= 311 && ln <= (full ? 335 : 318));
  endfunction

  // behavioural model of the position the outputs should show
  int mh = 0, ml = 1;
  bit m625 = 0, mProg = 0;
  bit hsHist[$] = '{0, 0, 0};
  bit fdHist[$] = '{0, 0, 0};

  always @(negedge clk) begin
    if (running && !finished) begin
      bit expVbi, expAct, rawHs, rawFd;
      int st, lo, hi, tot, frm;
      string vtag;
      expVbi = vbiRef(ml, mh, m625, mProg, snapFull);
      st = m625 ? S625 : S525;
      lo = st + (snapTrim ? TRIM : 0);
      hi = st + ALEN - (snapTrim ? TRIM : 0);
      expAct = (mh >= lo) && (mh < hi) && !expVbi;
      rawHs = (mh < HSW);
      rawFd = !mProg && (ml >= (m625 ? 313 : 264));
      hsHist.push_front(rawHs);
      fdHist.push_front(rawFd);
      if (hsHist.size() > 4) void'(hsHist.pop_back());
      if (fdHist.size() > 4) void'(fdHist.pop_back());
      vtag = mProg ? "R9 vbi" : (m625 ? "R8 vbi" : "R7 vbi");
      chk("R2 sampleNum", int'(sampleNum), mh);
      chk("R3 R4 lineNum", int'(lineNum), ml);
      chk(vtag, int'(vbiLine), int'(expVbi));
      chk("R10 activeVideo", int'(activeVideo), int'(expAct));
      chk("R5 R11 R12 hSyncOut", int'(hSyncOut), int'(hsHist[syncDelay] ^ hsInvert));
      chk("R6 R11 R12 fieldOut", int'(fieldOut), int'(fdHist[syncDelay] ^ fieldInvert));
      tot = m625 ? T625 : T525;
      frm = mProg ? (m625 ? 312 : 262) : (m625 ? 625 : 525);
      mh++;
      if (mh == tot) begin
        mh = 0;
        if (ml == frm) begin
          ml = 1; m625 = snap625; mProg = snapProg;   // R4 frame-boundary latch
        end else ml++;
      end
    end
  end

  task automatic waitPos(int ln);
    do @(negedge clk); while (!(int'(lineNum) == ln && sampleNum == 0));
    @(posedge clk); #2;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R1 reset state (std625 already requests 625, must be ignored)
    chk("R1 lineNum", int'(lineNum), 1);
    chk("R1 sampleNum", int'(sampleNum), 0);
    chk("R1 vbiLine", int'(vbiLine), 0);
    chk("R1 activeVideo", int'(activeVideo), 0);
    chk("R1 hSyncOut", int'(hSyncOut), 0);
    chk("R1 fieldOut", int'(fieldOut), 1);
    @(posedge clk); #2 rstN = 1;
    @(posedge clk); #1 running = 1;
    // frame 1: 525 interlaced
    waitPos(100); syncDelay = 2; hsInvert = 1;
    waitPos(250); fullVbi = 0;
    waitPos(300); fieldInvert = 0;
    // frame 2: 625 interlaced
    waitPos(1);
    waitPos(50);  syncDelay = 3; fullVbi = 1;
    waitPos(200); trimLine = 1;
    waitPos(300); fullVbi = 0; progressive = 1; fieldInvert = 1;
    // frame 3: 625 non-interlaced, partial then full
    waitPos(1);
    waitPos(3);   syncDelay = 1; fullVbi = 1;
    waitPos(100); std625 = 0;
    // frame 4: 525 non-interlaced
    waitPos(1);
    waitPos(30);  trimLine = 0; fullVbi = 0; progressive = 0; syncDelay = 0;
    // frame 5: 525 interlaced partial
    waitPos(1);
    waitPos(300); hsInvert = 0;
    waitPos(525);
    repeat (T525 + 4) @(posedge clk);
    finished = 1;
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nErrors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
    end
  end
endmodule